// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block holds the time of day and the calendar date as packed BCD bytes and advances them once per second. The host reaches the state through a plain byte-addressed register port: address, write data, a write strobe and a combinational read-data output. The last stage of the prescaler lives inside the block. It counts `TICKS_PER_SEC` pulses of a supplied sub-second tick to form each second, and its phase is cleared whenever counting is halted.

A control bit halts all counting while the host installs a new time. The host sets the halt bit, writes the seven time bytes, then clears the halt bit. The first second after that completes a full `TICKS_PER_SEC` sub-ticks later. A sticky "contents untrusted" flag sits in the top bit of the seconds byte. A low-voltage input sets it, and any host write to the seconds byte clears it. A century bit in the month byte toggles each time the two-digit year rolls from 99 to 00.

There is no data stream here. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the block reads: control 0x00, seconds 0x80 (untrusted flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 (century 0), year 0x00.
- R2: Register map. Address 0x0 is control, with the halt bit at bit 5 and all other bits reading 0. Addresses 0x2 to 0x8 are seconds, minutes, hours, day, weekday, month and year. The stored widths are 7, 7, 6, 6, 3, 5 and 8 bits; written bits above each width are dropped and read back as 0. Every other address reads 0x00.
- R3: Seconds and minutes count 00 to 59 in BCD, and hours count 00 to 23. Each wrap carries into the next field.
- R4: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In February the day wraps after 29 when the BCD year is a multiple of four (00 included), and after 28 otherwise. A day wrap advances the month, and month 12 wraps to 01 and advances the year.
- R5: The weekday (0 = Sunday) advances together with the day and wraps from 6 to 0.
- R6: A year wrap from 99 to 00 toggles the century bit, which is bit 7 of the month byte. That bit is also written through bit 7 of a month write.
- R7: While the halt bit is 1, no time field changes and sub-ticks are ignored.
- R8: The sub-tick phase is held at zero while halted, so after the halt bit clears, the seconds advance only on the `TICKS_PER_SEC`-th sub-tick.
- R9: The untrusted flag (seconds bit 7) is set by `low_volt` and stays set. A host write to the seconds byte clears it, and `low_volt` wins when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle pulse, `TICKS_PER_SEC` per second |
| low_volt | input | 1 | Supply-low indication; sets the untrusted flag |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one byte per cycle |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
The bench targets the rollovers that depend on the calendar: 30-day and 31-day months, February in leap and non-leap BCD years (including year 00 and years with an odd tens digit), the year-end wrap with both century values, and a BCD nibble carry in hours. A day-length error would show as a 31st day in a short month, or a missing 29th in a leap February. A century error would leave month bit 7 unchanged after 99 rolls to 00. The prescaler phase test halts the block midway through a second. A design that kept the old phase would advance early after the halt bit clears. The untrusted-flag test makes `low_volt` and a seconds write collide in one cycle, which catches a wrong priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 7;
  localparam logic [3:0] ADDR_CTRL = 4'h0;
  localparam logic [3:0] ADDR_SEC  = 4'h2;
  localparam logic [3:0] ADDR_MON  = 4'h7;
  localparam int HALT_BIT = 5;

  // index order: sec, min, hour, day, weekday, month, year
  function automatic logic [7:0] fld_min(input int i);
    return (i == 3 || i == 5) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] fld_mask(input int i);
    case (i)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic bcd_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_phase.sv
module rtc_phase #(
  parameter int TICKS_PER_SEC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic sub_tick,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (halt)     phase_q <= '0;
    else if (sub_tick) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign sec_pulse = !halt && sub_tick && (phase_q == LAST);
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MINV = 8'h00,
  parameter logic [7:0] MASK = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic [7:0] max_val,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] q,
  output logic       wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= MINV;
    else if (wr)  q <= wdata & MASK;
    else if (inc) q <= (q == max_val) ? MINV : rtc_pkg::bcd_next(q);
  end

  assign wrap = inc && (q == max_val);
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int TICKS_PER_SEC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       low_volt,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata
);
  import rtc_pkg::*;

  logic       halt_q;
  logic       vl_q;
  logic       cent_q;
  logic       sec_pulse;
  logic [7:0] fld_q   [NFIELD];
  logic       fld_inc [NFIELD];
  logic       fld_wrap[NFIELD];
  logic [7:0] fld_max [NFIELD];
  logic       fld_wr  [NFIELD];

  rtc_phase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_phase (
    .clk(clk), .rst_n(rst_n), .halt(halt_q), .sub_tick(sub_tick), .sec_pulse(sec_pulse)
  );

  // carry chain: weekday and day both advance on the hour wrap
  assign fld_inc[0] = sec_pulse;
  assign fld_inc[1] = fld_wrap[0];
  assign fld_inc[2] = fld_wrap[1];
  assign fld_inc[3] = fld_wrap[2];
  assign fld_inc[4] = fld_wrap[2];
  assign fld_inc[5] = fld_wrap[3];
  assign fld_inc[6] = fld_wrap[5];

  assign fld_max[0] = 8'h59;
  assign fld_max[1] = 8'h59;
  assign fld_max[2] = 8'h23;
  assign fld_max[3] = last_day(fld_q[5], fld_q[6]);
  assign fld_max[4] = 8'h06;
  assign fld_max[5] = 8'h12;
  assign fld_max[6] = 8'h99;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    assign fld_wr[i] = reg_we && (reg_addr == ADDR_SEC + 4'(i));
    rtc_bcd_field #(.MINV(fld_min(i)), .MASK(fld_mask(i))) u_fld (
      .clk(clk), .rst_n(rst_n), .inc(fld_inc[i]), .max_val(fld_max[i]),
      .wr(fld_wr[i]), .wdata(reg_wdata), .q(fld_q[i]), .wrap(fld_wrap[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      vl_q   <= 1'b1;
      cent_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == ADDR_CTRL) halt_q <= reg_wdata[HALT_BIT];
      if (low_volt)       vl_q <= 1'b1;
      else if (fld_wr[0]) vl_q <= 1'b0;
      if (fld_wr[5])        cent_q <= reg_wdata[7];
      else if (fld_wrap[6]) cent_q <= ~cent_q;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      4'h0: reg_rdata[HALT_BIT] = halt_q;
      4'h2: reg_rdata = {vl_q, fld_q[0][6:0]};
      4'h3: reg_rdata = fld_q[1];
      4'h4: reg_rdata = fld_q[2];
      4'h5: reg_rdata = fld_q[3];
      4'h6: reg_rdata = fld_q[4];
      4'h7: reg_rdata = {cent_q, 2'b00, fld_q[5][4:0]};
      4'h8: reg_rdata = fld_q[6];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt,
  input logic       sec_pulse,
  input logic       low_volt,
  input logic       reg_we,
  input logic [3:0] reg_addr,
  input logic       vl,
  input logic       cent,
  input logic [7:0] sec,
  input logic [7:0] mins,
  input logic [7:0] hour,
  input logic [7:0] day,
  input logic [7:0] wday,
  input logic [7:0] mon,
  input logic [7:0] year
);
  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reg_we) |=> ($stable(sec) && $stable(mins) && $stable(hour) &&
                           $stable(day) && $stable(wday) && $stable(mon) && $stable(year)));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && sec == 8'h59 && !reg_we) |=> (sec == 8'h00));

  // R9
  lv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_volt |=> vl);

  // R9
  lv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h2 && !low_volt) |=> !vl);

  // R5
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && sec == 8'h59 && mins == 8'h59 && hour == 8'h23 && wday == 8'h06 && !reg_we)
      |=> (wday == 8'h00));

  // R6
  century_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && sec == 8'h59 && mins == 8'h59 && hour == 8'h23 && day == 8'h31 &&
     mon == 8'h12 && year == 8'h99 && !reg_we) |=> (cent != $past(cent)));
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt_q), .sec_pulse(sec_pulse), .low_volt(low_volt),
  .reg_we(reg_we), .reg_addr(reg_addr), .vl(vl_q), .cent(cent_q),
  .sec(fld_q[0]), .mins(fld_q[1]), .hour(fld_q[2]), .day(fld_q[3]),
  .wday(fld_q[4]), .mon(fld_q[5]), .year(fld_q[6])
);

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int TPS = 8;
  localparam int NV  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_tick = 1'b0;
  logic       low_volt = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .low_volt(low_volt),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  // {start sec,min,hour,day,wday,month,year} , {expected after one second}
  localparam logic [111:0] VEC [NV] = '{
    {56'h00_00_00_01_00_01_24, 56'h01_00_00_01_00_01_24},  // R3 plain second
    {56'h59_00_00_01_00_01_24, 56'h00_01_00_01_00_01_24},  // R3 minute carry
    {56'h59_59_09_15_01_07_12, 56'h00_00_10_15_01_07_12},  // R3 hour nibble carry
    {56'h59_59_23_30_06_04_23, 56'h00_00_00_01_00_05_23},  // R4 30-day month, R5
    {56'h59_59_23_30_06_01_07, 56'h00_00_00_31_00_01_07},  // R4 31-day month, R5
    {56'h59_59_23_31_00_01_10, 56'h00_00_00_01_01_02_10},  // R4 january end
    {56'h59_59_23_30_02_06_10, 56'h00_00_00_01_03_07_10},  // R4 june end
    {56'h59_59_23_30_04_11_05, 56'h00_00_00_01_05_12_05},  // R4 november end
    {56'h59_59_23_28_02_02_23, 56'h00_00_00_01_03_03_23},  // R4 non-leap feb
    {56'h59_59_23_28_00_02_10, 56'h00_00_00_01_01_03_10},  // R4 non-leap feb
    {56'h59_59_23_28_02_02_24, 56'h00_00_00_29_03_02_24},  // R4 leap feb
    {56'h59_59_23_28_00_02_16, 56'h00_00_00_29_01_02_16},  // R4 leap, odd tens
    {56'h59_59_23_28_01_02_00, 56'h00_00_00_29_02_02_00},  // R4 year 00 leap
    {56'h59_59_23_29_03_02_24, 56'h00_00_00_01_04_03_24},  // R4 leap feb end
    {56'h59_59_23_31_05_12_99, 56'h00_00_00_01_06_81_00},  // R6 century 0->1
    {56'h59_59_23_31_05_92_99, 56'h00_00_00_01_06_01_00}   // R6 century 1->0
  };

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sub_tick = 1'b1;
      @(negedge clk); sub_tick = 1'b0;
    end
  endtask

  task automatic load_time(input logic [55:0] t);
    wr(4'h0, 8'h20);
    for (int k = 0; k < 7; k++) wr(4'(2 + k), t[55 - 8*k -: 8]);
    wr(4'h0, 8'h00);
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] b;
    for (int k = 0; k < 7; k++) begin
      rd(4'(2 + k), b);
      t[55 - 8*k -: 8] = b;
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    read_time(t);
    check("R1 time regs", {8'h0, t}, {8'h0, 56'h80_00_00_01_00_01_00});
    rd(4'h0, b); check("R1 control", {56'h0, b}, 64'h0);
    // R2 unmapped addresses
    rd(4'h1, b); check("R2 addr 1", {56'h0, b}, 64'h0);
    rd(4'hF, b); check("R2 addr F", {56'h0, b}, 64'h0);

    // R3 R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      load_time(VEC[i][111:56]);
      ticks(TPS);
      read_time(t);
      check($sformatf("R3/R4/R5/R6 vector %0d", i), {8'h0, t}, {8'h0, VEC[i][55:0]});
    end

    // R2 masking and control bit
    wr(4'h0, 8'hFF);
    rd(4'h0, b); check("R2 control readback", {56'h0, b}, 64'h20);
    wr(4'h3, 8'hFF); wr(4'h6, 8'hFF); wr(4'h7, 8'h7F);
    rd(4'h3, b); check("R2 minute mask", {56'h0, b}, 64'h7F);
    rd(4'h6, b); check("R2 weekday mask", {56'h0, b}, 64'h07);
    rd(4'h7, b); check("R2 month mask", {56'h0, b}, 64'h1F);

    // R7 halt freezes everything
    load_time(56'h10_20_05_12_03_05_30);
    wr(4'h0, 8'h20);
    ticks(3 * TPS);
    read_time(t);
    check("R7 halted", {8'h0, t}, {8'h0, 56'h10_20_05_12_03_05_30});
    wr(4'h0, 8'h00);

    // R8 phase cleared by halt
    ticks(3);
    wr(4'h0, 8'h20);
    wr(4'h0, 8'h00);
    ticks(TPS - 1);
    rd(4'h2, b); check("R8 before full second", {56'h0, b}, 64'h10);
    ticks(1);
    rd(4'h2, b); check("R8 at full second", {56'h0, b}, 64'h11);

    // R9 untrusted flag
    @(negedge clk); low_volt = 1'b1;
    @(negedge clk); low_volt = 1'b0;
    rd(4'h2, b); check("R9 set by low_volt", {56'h0, b[7]}, 64'h1);
    repeat (3) @(negedge clk);
    rd(4'h2, b); check("R9 sticky", {56'h0, b[7]}, 64'h1);
    wr(4'h2, 8'h45);
    rd(4'h2, b); check("R9 cleared by write", {56'h0, b}, 64'h45);
    @(negedge clk);
    reg_addr = 4'h2; reg_wdata = 8'h30; reg_we = 1'b1; low_volt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; low_volt = 1'b0;
    rd(4'h2, b); check("R9 low_volt wins", {56'h0, b}, 64'hB0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule